// File: doc/BRIEF.md
# Interrupt Moderation Delay Timers

This block holds the interrupt moderation timers of a descriptor-driven network controller. Four countdown timers delay the receive-timer and transmit-written-back interrupt causes so that a burst of completions produces one interrupt instead of many. For each direction there is a per-packet timer, which restarts from its full delay every time a packet completes. There is also an absolute timer, which starts with the first packet of a burst and runs to the end without being restarted. All timers count a common 1024 ns tick. A prescaler derives that tick from the clock period parameter.

Alongside the timers, the block judges each received packet against two limits. It raises a descriptors-low cause when the remaining descriptor count has fallen to a selectable fraction of the ring. It raises a short-packet cause when the received length is at or below a programmable size. Every cause leaves the block as a single-cycle pulse toward the interrupt controller.

When the interrupt controller actually delivers an interrupt to the processor, it pulses `irq_posted`. Every running timer is then cancelled, and a timer cancelled this way still reports its cause, so that no pending moderation event is lost. A separate `flush_req` pulse raises the receive-timer cause at once. This is the path taken when software reads the packet-delay setting with its flush flag set.

Top module: `irq_delay_timers`

## Requirements
- R1: A tick occurs once every TICK_NS/CLK_NS clock cycles. The first tick comes on the (TICK_NS/CLK_NS)-th rising edge after reset is released. All delay fields count in these ticks.
- R2: A `rx_done` pulse with a nonzero `rx_pkt_delay` loads the receive packet timer with that delay, even if the timer is already running. When the timer expires on its delay-th tick, `rx_timer_cause` pulses for one cycle, one cycle after that tick edge.
- R3: A `rx_done` pulse starts the receive absolute timer from `rx_abs_delay` only when that timer is idle and both `rx_abs_delay` and `rx_pkt_delay` are nonzero. Later packets do not reload it. Its expiry also pulses `rx_timer_cause`.
- R4: The transmit packet and absolute timers follow the rules of R2 and R3, using `tx_pkt_delay` and `tx_abs_delay`. They start only on a `tx_done` pulse whose `tx_delay_req` is 1, and their expiry pulses `tx_wb_cause`.
- R5: An `irq_posted` pulse stops every running timer. In the next cycle, `rx_timer_cause` pulses if a receive timer was running, and `tx_wb_cause` pulses if a transmit timer was running. Idle timers raise nothing. A start that arrives in the same cycle reloads the timer after it is cancelled.
- R6: A `flush_req` pulse raises `rx_timer_cause` in the next cycle.
- R7: On each `rx_done`, `rx_low_cause` pulses in the next cycle if `desc_left` is at or below a threshold. The threshold is chosen by `low_sel`: 0 gives `ring_len`>>1, 1 gives `ring_len`>>2, and 2 gives `ring_len`>>3. A `low_sel` of 3 never raises the cause.
- R8: On each `rx_done`, `rx_short_cause` pulses in the next cycle if `rx_len` is less than or equal to `short_thresh`.
- R9: During and right after reset, all four cause outputs are 0 and no timer is running.
- R10: When the packet delay of a direction is zero, a completion starts neither timer of that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | Pulse: a received packet was written to memory |
| rx_len | input | LEN_W | Length of that received packet |
| tx_done | input | 1 | Pulse: a transmit descriptor was completed |
| tx_delay_req | input | 1 | The completed transmit descriptor asks for a delayed interrupt |
| rx_pkt_delay | input | DLY_W | Receive per-packet delay in ticks |
| rx_abs_delay | input | DLY_W | Receive absolute delay in ticks |
| tx_pkt_delay | input | DLY_W | Transmit per-packet delay in ticks |
| tx_abs_delay | input | DLY_W | Transmit absolute delay in ticks |
| short_thresh | input | LEN_W | Largest length counted as a short packet |
| ring_len | input | RING_W | Receive ring size used for the low threshold |
| desc_left | input | RING_W | Receive descriptors still free |
| low_sel | input | 2 | Low-threshold fraction select |
| irq_posted | input | 1 | Pulse: the interrupt was delivered to the processor |
| flush_req | input | 1 | Pulse: force the receive-timer cause now |
| rx_timer_cause | output | 1 | Receive-timer cause pulse |
| tx_wb_cause | output | 1 | Transmit-written-back cause pulse |
| rx_low_cause | output | 1 | Descriptors-low cause pulse |
| rx_short_cause | output | 1 | Short-packet cause pulse |

## Verification
The bench builds the block with CLK_NS=4 and TICK_NS=64, so a tick falls every 16 cycles. This brings multi-tick expiries, restarts that push an expiry back, and an absolute timer that caps a stream of restarts within a few hundred cycles. DLY_W=8, LEN_W=14 and RING_W=12 keep the fields small. A ring length of 64 makes the three low thresholds exactly 32, 16 and 8, so each can be probed at its limit and one above it.

// File: rtl/irq_dly_pkg.sv
package irq_dly_pkg;

  // Index of each timer slot inside the timer bank.
  localparam int SLOT_RX_PKT = 0;
  localparam int SLOT_RX_ABS = 1;
  localparam int SLOT_TX_PKT = 2;
  localparam int SLOT_TX_ABS = 3;
  localparam int SLOTS       = 4;

  // Clock cycles per delay tick, never below one.
  function automatic int tick_div(input int clk_ns, input int tick_ns);
    int d;
    d = tick_ns / clk_ns;
    return (d < 1) ? 1 : d;
  endfunction

  // Descriptors-low decision: sel 0..2 pick 1/2, 1/4, 1/8 of the ring.
  function automatic logic low_hit(input logic [31:0] left,
                                   input logic [31:0] ring,
                                   input logic [1:0]  sel);
    logic [31:0] limit;
    if (sel == 2'd3) return 1'b0;
    limit = ring >> (32'(sel) + 32'd1);
    return left <= limit;
  endfunction

  // Short-packet decision.
  function automatic logic short_hit(input logic [31:0] len,
                                     input logic [31:0] lim);
    return len <= lim;
  endfunction

endpackage

// File: rtl/dly_prescaler.sv
module dly_prescaler #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + CW'(1);
  end
endmodule

// File: rtl/dly_timer.sv
module dly_timer #(
  parameter int W       = 16,
  parameter bit RESTART = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         arm,
  input  logic         enable,
  input  logic         cancel,
  input  logic [W-1:0] load,
  output logic         fire,
  output logic         active,
  output logic [W-1:0] remain
);
  logic [W-1:0] cnt;
  logic         may_start;
  logic         start;
  logic         last_tick;

  generate
    if (RESTART) begin : g_restart
      assign may_start = 1'b1;
    end else begin : g_once
      assign may_start = ~active | cancel;
    end
  endgenerate

  assign start     = arm & enable & (load != '0) & may_start;
  assign last_tick = tick & active & (cnt <= W'(1));
  assign remain    = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      fire   <= 1'b0;
    end else if (start) begin
      cnt    <= load;
      active <= 1'b1;
      fire   <= cancel & active;
    end else if (cancel) begin
      cnt    <= '0;
      active <= 1'b0;
      fire   <= active;
    end else if (last_tick) begin
      cnt    <= '0;
      active <= 1'b0;
      fire   <= 1'b1;
    end else begin
      if (tick && active) cnt <= cnt - W'(1);
      fire <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_ring_events.sv
module rx_ring_events
  import irq_dly_pkg::*;
#(
  parameter int LEN_W  = 14,
  parameter int RING_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [LEN_W-1:0]  short_thresh,
  input  logic [RING_W-1:0] ring_len,
  input  logic [RING_W-1:0] desc_left,
  input  logic [1:0]        low_sel,
  output logic              low_pulse,
  output logic              short_pulse
);
  logic low_now;
  logic short_now;

  assign low_now   = low_hit(32'(desc_left), 32'(ring_len), low_sel);
  assign short_now = short_hit(32'(rx_len), 32'(short_thresh));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_pulse   <= 1'b0;
      short_pulse <= 1'b0;
    end else begin
      low_pulse   <= rx_done & low_now;
      short_pulse <= rx_done & short_now;
    end
  end
endmodule

// File: rtl/irq_delay_timers.sv
module irq_delay_timers
  import irq_dly_pkg::*;
#(
  parameter int CLK_NS  = 4,
  parameter int TICK_NS = 1024,
  parameter int DLY_W   = 16,
  parameter int LEN_W   = 14,
  parameter int RING_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              tx_done,
  input  logic              tx_delay_req,
  input  logic [DLY_W-1:0]  rx_pkt_delay,
  input  logic [DLY_W-1:0]  rx_abs_delay,
  input  logic [DLY_W-1:0]  tx_pkt_delay,
  input  logic [DLY_W-1:0]  tx_abs_delay,
  input  logic [LEN_W-1:0]  short_thresh,
  input  logic [RING_W-1:0] ring_len,
  input  logic [RING_W-1:0] desc_left,
  input  logic [1:0]        low_sel,
  input  logic              irq_posted,
  input  logic              flush_req,
  output logic              rx_timer_cause,
  output logic              tx_wb_cause,
  output logic              rx_low_cause,
  output logic              rx_short_cause
);
  localparam int TICK_DIV = tick_div(CLK_NS, TICK_NS);

  // Named internal events, visible to the bound checker.
  logic                        tick;
  logic                        tx_arm;
  logic                        flush_q;
  logic [SLOTS-1:0]            timer_arm;
  logic [SLOTS-1:0]            timer_en;
  logic [SLOTS-1:0]            timer_fire;
  logic [SLOTS-1:0]            timer_active;
  logic [SLOTS-1:0][DLY_W-1:0] timer_load;
  logic [SLOTS-1:0][DLY_W-1:0] timer_remain;

  dly_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  assign tx_arm = tx_done & tx_delay_req;

  assign timer_arm  = {tx_arm, tx_arm, rx_done, rx_done};
  assign timer_en   = {(tx_pkt_delay != '0), 1'b1, (rx_pkt_delay != '0), 1'b1};
  assign timer_load = {tx_abs_delay, tx_pkt_delay, rx_abs_delay, rx_pkt_delay};

  // Even slots restart on every completion, odd slots run once per burst.
  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_tmr
      dly_timer #(
        .W       (DLY_W),
        .RESTART ((g % 2) == 0)
      ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .arm    (timer_arm[g]),
        .enable (timer_en[g]),
        .cancel (irq_posted),
        .load   (timer_load[g]),
        .fire   (timer_fire[g]),
        .active (timer_active[g]),
        .remain (timer_remain[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_req;
  end

  assign rx_timer_cause = timer_fire[SLOT_RX_PKT] | timer_fire[SLOT_RX_ABS] | flush_q;
  assign tx_wb_cause    = timer_fire[SLOT_TX_PKT] | timer_fire[SLOT_TX_ABS];

  rx_ring_events #(.LEN_W(LEN_W), .RING_W(RING_W)) u_ring (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_done      (rx_done),
    .rx_len       (rx_len),
    .short_thresh (short_thresh),
    .ring_len     (ring_len),
    .desc_left    (desc_left),
    .low_sel      (low_sel),
    .low_pulse    (rx_low_cause),
    .short_pulse  (rx_short_cause)
  );
endmodule

// File: rtl/irq_delay_timers_chk.sv
module irq_delay_timers_chk #(
  parameter int TICK_DIV = 256,
  parameter int DLY_W    = 16,
  parameter int LEN_W    = 14
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  rx_done,
  input logic [LEN_W-1:0]      rx_len,
  input logic [LEN_W-1:0]      short_thresh,
  input logic [1:0]            low_sel,
  input logic                  tx_done,
  input logic                  tx_delay_req,
  input logic [DLY_W-1:0]      rx_pkt_delay,
  input logic                  irq_posted,
  input logic                  flush_req,
  input logic                  rx_timer_cause,
  input logic                  tx_wb_cause,
  input logic                  rx_low_cause,
  input logic                  rx_short_cause,
  input logic [3:0]            timer_active,
  input logic [3:0][DLY_W-1:0] timer_remain
);
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (TICK_DIV > 1) && tick |=> !tick);

  generate
    for (genvar k = 0; k < 4; k++) begin : g_live
      assert_live_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        timer_active[k] |-> timer_remain[k] != '0);
    end
  endgenerate

  assert_abs_no_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timer_active[1] && $past(timer_active[1]) && !$past(irq_posted)
      |-> timer_remain[1] <= $past(timer_remain[1]));

  assert_tx_abs_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_active[3]) |-> $past(tx_done && tx_delay_req));

  assert_tx_pkt_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_active[2]) |-> $past(tx_done && tx_delay_req));

  assert_tx_cause_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wb_cause |-> $past(tick || irq_posted));

  assert_cancel_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_posted && !rx_done && !(tx_done && tx_delay_req) |=> timer_active == 4'b0000);

  assert_rx_cause_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timer_cause |-> $past(tick || irq_posted || flush_req));

  assert_low_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_low_cause |-> $past(rx_done) && ($past(low_sel) != 2'd3));

  assert_short_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_short_cause |-> $past(rx_done && (rx_len <= short_thresh)));

  assert_zero_delay_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_active[0]) || $rose(timer_active[1]) |-> $past(rx_pkt_delay) != '0);
endmodule

bind irq_delay_timers irq_delay_timers_chk #(
  .TICK_DIV (TICK_DIV),
  .DLY_W    (DLY_W),
  .LEN_W    (LEN_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick           (tick),
  .rx_done        (rx_done),
  .rx_len         (rx_len),
  .short_thresh   (short_thresh),
  .low_sel        (low_sel),
  .tx_done        (tx_done),
  .tx_delay_req   (tx_delay_req),
  .rx_pkt_delay   (rx_pkt_delay),
  .irq_posted     (irq_posted),
  .flush_req      (flush_req),
  .rx_timer_cause (rx_timer_cause),
  .tx_wb_cause    (tx_wb_cause),
  .rx_low_cause   (rx_low_cause),
  .rx_short_cause (rx_short_cause),
  .timer_active   (timer_active),
  .timer_remain   (timer_remain)
);

// File: tb/tb_irq_delay_timers.sv
`timescale 1ns/1ps
module tb_irq_delay_timers;
  localparam int CLK_NS  = 4;
  localparam int TICK_NS = 64;
  localparam int DIV     = TICK_NS / CLK_NS;
  localparam int DLY_W   = 8;
  localparam int LEN_W   = 14;
  localparam int RING_W  = 12;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_done = 0, tx_done = 0, tx_delay_req = 0;
  logic [LEN_W-1:0]  rx_len = 100;
  logic [DLY_W-1:0]  rx_pkt_delay = 0, rx_abs_delay = 0, tx_pkt_delay = 0, tx_abs_delay = 0;
  logic [LEN_W-1:0]  short_thresh = 0;
  logic [RING_W-1:0] ring_len = 64, desc_left = 64;
  logic [1:0]        low_sel = 2'd3;
  logic irq_posted = 0, flush_req = 0;
  logic rx_timer_cause, tx_wb_cause, rx_low_cause, rx_short_cause;

  always #2 clk = ~clk;

  irq_delay_timers #(
    .CLK_NS(CLK_NS), .TICK_NS(TICK_NS), .DLY_W(DLY_W), .LEN_W(LEN_W), .RING_W(RING_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_len(rx_len),
    .tx_done(tx_done), .tx_delay_req(tx_delay_req),
    .rx_pkt_delay(rx_pkt_delay), .rx_abs_delay(rx_abs_delay),
    .tx_pkt_delay(tx_pkt_delay), .tx_abs_delay(tx_abs_delay),
    .short_thresh(short_thresh), .ring_len(ring_len), .desc_left(desc_left),
    .low_sel(low_sel), .irq_posted(irq_posted), .flush_req(flush_req),
    .rx_timer_cause(rx_timer_cause), .tx_wb_cause(tx_wb_cause),
    .rx_low_cause(rx_low_cause), .rx_short_cause(rx_short_cause)
  );

  int checks = 0;
  int failures = 0;
  int cycle = 0;
  bit done = 0;
  string cur_req = "R9";

  // Behavioural reference: a tick counter and four countdowns.
  int pc = 0;
  int act[4];
  int cnt[4];
  bit e_rx = 0, e_tx = 0, e_low = 0, e_short = 0;

  always @(posedge clk) begin
    bit tk;
    bit fr[4];
    if (!rst_n) begin
      pc = 0;
      for (int i = 0; i < 4; i++) begin act[i] = 0; cnt[i] = 0; end
      e_rx = 0; e_tx = 0; e_low = 0; e_short = 0;
    end else begin
      tk = (pc == DIV - 1);
      pc = tk ? 0 : pc + 1;
      for (int i = 0; i < 4; i++) begin
        bit rx_side, per_pkt, arm, st;
        int ld, pk;
        rx_side = (i < 2);
        per_pkt = (i % 2 == 0);
        arm = rx_side ? rx_done : (tx_done && tx_delay_req);
        pk  = rx_side ? int'(rx_pkt_delay) : int'(tx_pkt_delay);
        case (i)
          0: ld = int'(rx_pkt_delay);
          1: ld = int'(rx_abs_delay);
          2: ld = int'(tx_pkt_delay);
          default: ld = int'(tx_abs_delay);
        endcase
        st = arm && pk != 0 && ld != 0 && (per_pkt || act[i] == 0 || irq_posted);
        fr[i] = 0;
        if (st) begin
          fr[i] = irq_posted && act[i] != 0;
          act[i] = 1; cnt[i] = ld;
        end else if (irq_posted) begin
          fr[i] = act[i] != 0;
          act[i] = 0; cnt[i] = 0;
        end else if (tk && act[i] != 0) begin
          cnt[i] = cnt[i] - 1;
          if (cnt[i] <= 0) begin act[i] = 0; cnt[i] = 0; fr[i] = 1; end
        end
      end
      e_rx = fr[0] | fr[1] | flush_req;
      e_tx = fr[2] | fr[3];
      e_low = rx_done && low_sel != 2'd3 && (int'(desc_left) <= (int'(ring_len) / (2 << low_sel)));
      e_short = rx_done && (int'(rx_len) <= int'(short_thresh));
    end
  end

  task automatic chk(input logic got, input bit exp, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", cur_req, what, got, exp, cycle);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rx_timer_cause, e_rx, "rx_timer_cause");
      chk(tx_wb_cause, e_tx, "tx_wb_cause");
      chk(rx_low_cause, e_low, "rx_low_cause");
      chk(rx_short_cause, e_short, "rx_short_cause");
    end
  end

  always @(posedge clk) begin
    cycle++;
    if (cycle > WATCHDOG && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycle, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_pkt(input int len);
    @(negedge clk); rx_done = 1; rx_len = LEN_W'(len);
    @(negedge clk); rx_done = 0;
  endtask

  task automatic tx_desc(input bit req);
    @(negedge clk); tx_done = 1; tx_delay_req = req;
    @(negedge clk); tx_done = 0; tx_delay_req = 0;
  endtask

  task automatic post_irq();
    @(negedge clk); irq_posted = 1;
    @(negedge clk); irq_posted = 0;
  endtask

  initial begin
    // R9: outputs quiet during reset
    idle(3);
    chk(rx_timer_cause, 0, "R9 reset rx_timer_cause");
    chk(tx_wb_cause, 0, "R9 reset tx_wb_cause");
    chk(rx_low_cause, 0, "R9 reset rx_low_cause");
    chk(rx_short_cause, 0, "R9 reset rx_short_cause");
    @(negedge clk); rst_n = 1;
    idle(40);

    // R1 / R2: single expiry, restart pushing expiry back
    cur_req = "R2";
    rx_pkt_delay = 3;
    rx_pkt(100); idle(80);
    rx_pkt(100); idle(25); rx_pkt(100); idle(20); rx_pkt(100); idle(90);
    cur_req = "R1";
    rx_pkt_delay = 1;
    rx_pkt(100); idle(5); rx_pkt(100); idle(40);

    // R3: absolute timer caps a stream of restarts
    cur_req = "R3";
    rx_pkt_delay = 4; rx_abs_delay = 6;
    for (int k = 0; k < 8; k++) begin rx_pkt(100); idle(20); end
    idle(120);

    // R10: zero packet delay starts nothing
    cur_req = "R10";
    rx_pkt_delay = 0; rx_abs_delay = 5;
    rx_pkt(100); idle(120);

    // R4: transmit timers only on delay-requesting descriptors
    cur_req = "R4";
    tx_pkt_delay = 2; tx_abs_delay = 5;
    tx_desc(0); idle(60);
    for (int k = 0; k < 6; k++) begin tx_desc(1); idle(18); end
    idle(120);
    tx_pkt_delay = 0; tx_desc(1); idle(120);

    // R5: delivery cancels running timers and reports them
    cur_req = "R5";
    rx_pkt_delay = 6; rx_abs_delay = 9; tx_pkt_delay = 6; tx_abs_delay = 0;
    rx_pkt(100); tx_desc(1); idle(30);
    post_irq(); idle(150);
    post_irq(); idle(10);
    rx_pkt(100); idle(10);
    @(negedge clk); irq_posted = 1; rx_done = 1;
    @(negedge clk); irq_posted = 0; rx_done = 0;
    idle(180);

    // R6: flush raises the receive cause
    cur_req = "R6";
    rx_pkt_delay = 0; rx_abs_delay = 0; tx_pkt_delay = 0;
    @(negedge clk); flush_req = 1;
    @(negedge clk); flush_req = 0;
    idle(5);

    // R7: low-descriptor thresholds 32/16/8 with ring of 64
    cur_req = "R7";
    ring_len = 64;
    for (int s = 0; s < 4; s++) begin
      low_sel = 2'(s);
      desc_left = RING_W'(64 >> (s + 1)); rx_pkt(100); idle(2);
      desc_left = RING_W'((64 >> (s + 1)) + 1); rx_pkt(100); idle(2);
      desc_left = 0; rx_pkt(100); idle(2);
    end
    low_sel = 2'd3; desc_left = 64;

    // R8: short packet at, below and above the limit
    cur_req = "R8";
    short_thresh = 60;
    rx_pkt(59); idle(2); rx_pkt(60); idle(2); rx_pkt(61); idle(2);
    short_thresh = 0; rx_pkt(0); idle(2); rx_pkt(1); idle(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule